// File: doc/BRIEF.md
# Virtual CPU Wake Doorbell Generator

This block keeps a small state table, one entry per virtual processor, and raises a physical "wake" interrupt when a virtual processor that is not running is given work. The wake interrupt is the processor's default doorbell. Each entry holds whether the processor is running, the doorbell-enable flag it was descheduled with, the group enables captured when it was last scheduled, and whether a doorbell has already been raised in the current idle period. It also holds the mapped doorbell interrupt ID. A hypervisor scheduler drives schedule and deschedule events. An interrupt-routing front end drives virtual interrupt state updates on several parallel lanes. The doorbell's receiver acknowledges it.

A doorbell goes pending at most once per idle period. When several become pending together, they are emitted one per cycle on a registered request port that carries the processor index and the mapped ID. Individual per-event doorbells, memory-resident tables and interrupt delivery are handled elsewhere.

Top module: `vdb_gen`

## Requirements
- R1: A virtual interrupt event with `vint_en`=1 and `vint_pend`=1 for an eligible processor sets that processor's bit in `db_pending` on the next clock edge. On the edge after that, `db_valid` pulses for one cycle with `db_vp` set to the processor and `db_id` set to its mapped ID.
- R2: No doorbell is raised for a processor that is currently scheduled (last event `sched_run`=1).
- R3: No doorbell is raised if the processor's most recent deschedule carried `sched_dben`=0. After reset every processor counts as descheduled with the flag at 1.
- R4: No doorbell is raised for a processor without a mapped ID (`map_set`=1 maps `map_id`, `map_set`=0 unmaps). An unmap also drops any pending doorbell.
- R5: A doorbell is raised at most once between a deschedule and the next schedule. An acknowledge does not re-arm it. A schedule followed by a deschedule does.
- R6: A schedule event clears that processor's `db_pending` bit and any emission not yet made.
- R7: An event with `vint_en`=0 or `vint_pend`=0 raises nothing. An event whose group (`vint_grp`: 0 or 1) was disabled in `sched_grp` (bit 0 = group 0, bit 1 = group 1) at the last schedule raises nothing. A processor never scheduled since reset treats both groups as enabled.
- R8: An acknowledge clears a pending doorbell. An acknowledge for a processor with no pending doorbell changes nothing.
- R9: Doorbells that become pending in the same cycle are emitted one per cycle, lowest processor index first. The others stay queued.
- R10: After reset `db_valid` is 0 and `db_pending` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_valid | input | 1 | Schedule/deschedule event strobe |
| sched_vp | input | $clog2(NUM_VP) | Target processor |
| sched_run | input | 1 | 1 = schedule, 0 = deschedule |
| sched_dben | input | 1 | Doorbell-enable flag for a deschedule |
| sched_grp | input | 2 | Group enables captured on schedule |
| map_valid | input | 1 | Doorbell map/unmap strobe |
| map_vp | input | $clog2(NUM_VP) | Target processor |
| map_set | input | 1 | 1 = map, 0 = unmap |
| map_id | input | ID_W | Doorbell interrupt ID |
| vint_valid | input | LANES | Per-lane virtual interrupt event strobe |
| vint_vp | input | LANES*$clog2(NUM_VP) | Per-lane processor, lane n in slice n |
| vint_en | input | LANES | Interrupt individually enabled after the event |
| vint_pend | input | LANES | Interrupt pending after the event |
| vint_grp | input | LANES | Interrupt group |
| ack_valid | input | 1 | Doorbell acknowledge strobe |
| ack_vp | input | $clog2(NUM_VP) | Acknowledged processor |
| db_valid | output | 1 | Doorbell request |
| db_vp | output | $clog2(NUM_VP) | Processor of the request |
| db_id | output | ID_W | Mapped doorbell ID |
| db_pending | output | NUM_VP | Per-processor doorbell pending state |

## Verification
A table of single-lane events is applied to processors in differing states: never scheduled, descheduled with a group disabled, descheduled with the flag cleared, running, unmapped, and already fired. This separates each suppression condition from the firing path. Each row also varies the enable, pending and group inputs, so a wrong gate on one term misfires on a specific row. Directed sequences then cover acknowledge of pending and idle entries, re-arming through a schedule/deschedule pair, unmapping, and two lanes firing in one cycle, which shows the lowest-index emission order.

// File: rtl/vdb_pkg.sv
package vdb_pkg;
  // Per-processor control flags kept in each slot
  typedef struct packed {
    logic       run;    // currently scheduled
    logic       dben;   // doorbell-enable from last deschedule
    logic       fired;  // doorbell already raised this idle period
    logic       pend;   // doorbell pending
    logic       req;    // awaiting emission on the output port
    logic       idv;    // doorbell ID mapped
    logic [1:0] grp;    // group enables captured at schedule
  } vp_flags_t;

  localparam vp_flags_t VP_FLAGS_RESET = '{
    run: 1'b0, dben: 1'b1, fired: 1'b0, pend: 1'b0,
    req: 1'b0, idv: 1'b0, grp: 2'b11
  };
endpackage

// File: rtl/vdb_lowest_arb.sv
module vdb_lowest_arb #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx   = IW'(i);
      end
    end
    any = |req;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)) else $error("more than one grant"); // R9
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
    any |-> ((req & (grant - N'(1))) == '0)) else $error("grant not lowest"); // R9
endmodule

// File: rtl/vdb_vp_slot.sv
module vdb_vp_slot
  import vdb_pkg::*;
#(
  parameter int LANES = 2,
  parameter int ID_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sched_hit,
  input  logic             sched_run,
  input  logic             sched_dben,
  input  logic [1:0]       sched_grp,
  input  logic             map_hit,
  input  logic             map_set,
  input  logic [ID_W-1:0]  map_id,
  input  logic [LANES-1:0] lane_hit,
  input  logic [LANES-1:0] lane_ok,
  input  logic [LANES-1:0] lane_grp,
  input  logic             ack_hit,
  input  logic             grant,
  output logic             req_o,
  output logic             pend_o,
  output logic [ID_W-1:0]  id_o
);
  vp_flags_t        flags_q, flags_d;
  logic [ID_W-1:0]  id_q;
  logic [LANES-1:0] lane_fire;
  logic             fire;

  // A lane qualifies when it targets this slot, the interrupt is enabled
  // and pending, and its group was enabled at the last schedule.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_fire[l] = lane_hit[l] && lane_ok[l] &&
                          (lane_grp[l] ? flags_q.grp[1] : flags_q.grp[0]);
  end

  assign fire = (|lane_fire) && !flags_q.run && flags_q.dben &&
                flags_q.idv && !flags_q.fired;

  always_comb begin
    flags_d = flags_q;
    if (grant) flags_d.req = 1'b0;
    if (map_hit) flags_d.idv = map_set;
    if (sched_hit) begin
      if (sched_run) begin
        flags_d.run   = 1'b1;
        flags_d.grp   = sched_grp;
        flags_d.pend  = 1'b0;
        flags_d.req   = 1'b0;
        flags_d.fired = 1'b0;
      end else begin
        flags_d.dben = sched_dben;
        if (flags_q.run) begin
          flags_d.run   = 1'b0;
          flags_d.fired = 1'b0;
        end
      end
    end else if (map_hit && !map_set) begin
      flags_d.pend = 1'b0;
      flags_d.req  = 1'b0;
    end else if (fire) begin
      flags_d.fired = 1'b1;
      flags_d.pend  = 1'b1;
      flags_d.req   = 1'b1;
    end else if (ack_hit) begin
      flags_d.pend = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= VP_FLAGS_RESET;
      id_q    <= '0;
    end else begin
      flags_q <= flags_d;
      if (map_hit && map_set) id_q <= map_id;
    end
  end

  assign req_o  = flags_q.req;
  assign pend_o = flags_q.pend;
  assign id_o   = id_q;

  AST_NO_FIRE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q.pend) |-> !flags_q.run) else $error("doorbell while running"); // R2
  AST_NEEDS_ID: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q.pend) |-> $past(flags_q.idv)) else $error("doorbell without id"); // R4
  AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (flags_q.fired && !sched_hit) |=> !$rose(flags_q.pend)) else $error("second doorbell"); // R5
  AST_SCHED_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sched_hit && sched_run) |=> (!flags_q.pend && !flags_q.req)) else $error("schedule left pending"); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && flags_q.pend && !sched_hit && !map_hit) |=> !flags_q.pend) else $error("ack ignored"); // R8
endmodule

// File: rtl/vdb_gen.sv
module vdb_gen
  import vdb_pkg::*;
#(
  parameter int NUM_VP = 16,
  parameter int LANES  = 2,
  parameter int ID_W   = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sched_valid,
  input  logic [$clog2(NUM_VP)-1:0]         sched_vp,
  input  logic                              sched_run,
  input  logic                              sched_dben,
  input  logic [1:0]                        sched_grp,
  input  logic                              map_valid,
  input  logic [$clog2(NUM_VP)-1:0]         map_vp,
  input  logic                              map_set,
  input  logic [ID_W-1:0]                   map_id,
  input  logic [LANES-1:0]                  vint_valid,
  input  logic [LANES*$clog2(NUM_VP)-1:0]   vint_vp,
  input  logic [LANES-1:0]                  vint_en,
  input  logic [LANES-1:0]                  vint_pend,
  input  logic [LANES-1:0]                  vint_grp,
  input  logic                              ack_valid,
  input  logic [$clog2(NUM_VP)-1:0]         ack_vp,
  output logic                              db_valid,
  output logic [$clog2(NUM_VP)-1:0]         db_vp,
  output logic [ID_W-1:0]                   db_id,
  output logic [NUM_VP-1:0]                 db_pending
);
  localparam int VP_W = $clog2(NUM_VP);

  logic [NUM_VP-1:0] req_vec, grant_vec;
  logic [ID_W-1:0]   id_tab [NUM_VP];
  logic [VP_W-1:0]   grant_idx;
  logic              grant_any;
  logic [LANES-1:0]  lane_ok;

  assign lane_ok = vint_en & vint_pend;

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    logic [LANES-1:0] lane_hit;
    for (genvar l = 0; l < LANES; l++) begin : g_dec
      assign lane_hit[l] = vint_valid[l] &&
                           (vint_vp[l*VP_W +: VP_W] == VP_W'(v));
    end

    vdb_vp_slot #(.LANES(LANES), .ID_W(ID_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .sched_hit  (sched_valid && (sched_vp == VP_W'(v))),
      .sched_run  (sched_run),
      .sched_dben (sched_dben),
      .sched_grp  (sched_grp),
      .map_hit    (map_valid && (map_vp == VP_W'(v))),
      .map_set    (map_set),
      .map_id     (map_id),
      .lane_hit   (lane_hit),
      .lane_ok    (lane_ok),
      .lane_grp   (vint_grp),
      .ack_hit    (ack_valid && (ack_vp == VP_W'(v))),
      .grant      (grant_vec[v]),
      .req_o      (req_vec[v]),
      .pend_o     (db_pending[v]),
      .id_o       (id_tab[v])
    );
  end

  vdb_lowest_arb #(.N(NUM_VP)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (req_vec),
    .grant (grant_vec),
    .idx   (grant_idx),
    .any   (grant_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      db_valid <= 1'b0;
      db_vp    <= '0;
      db_id    <= '0;
    end else begin
      db_valid <= grant_any;
      db_vp    <= grant_idx;
      db_id    <= id_tab[grant_idx];
    end
  end

  AST_OUT_IS_PENDING_OR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    grant_any |=> db_valid) else $error("grant not emitted"); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!db_valid && db_pending == '0)) else $error("not quiet after reset"); // R10
endmodule

// File: tb/vdb_gen_bench.sv
module vdb_gen_bench;
  localparam int NV = 16, NL = 2, IW = 16, VW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic           sched_valid = 0, sched_run = 0, sched_dben = 0;
  logic [VW-1:0]  sched_vp = 0;
  logic [1:0]     sched_grp = 0;
  logic           map_valid = 0, map_set = 0;
  logic [VW-1:0]  map_vp = 0;
  logic [IW-1:0]  map_id = 0;
  logic [NL-1:0]  vint_valid = 0, vint_en = 0, vint_pend = 0, vint_grp = 0;
  logic [NL*VW-1:0] vint_vp = 0;
  logic           ack_valid = 0;
  logic [VW-1:0]  ack_vp = 0;
  logic           db_valid;
  logic [VW-1:0]  db_vp;
  logic [IW-1:0]  db_id;
  logic [NV-1:0]  db_pending;

  vdb_gen #(.NUM_VP(NV), .LANES(NL), .ID_W(IW)) u_vdb_gen (.*);

  int total = 0, bad = 0;

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_sched(input int vp, input bit run, input bit dben, input bit [1:0] grp);
    @(negedge clk);
    sched_valid = 1; sched_vp = VW'(vp); sched_run = run; sched_dben = dben; sched_grp = grp;
    @(posedge clk); @(negedge clk);
    sched_valid = 0;
  endtask

  task automatic do_map(input int vp, input bit set, input int id);
    @(negedge clk);
    map_valid = 1; map_vp = VW'(vp); map_set = set; map_id = IW'(id);
    @(posedge clk); @(negedge clk);
    map_valid = 0;
  endtask

  task automatic do_ack(input int vp);
    @(negedge clk);
    ack_valid = 1; ack_vp = VW'(vp);
    @(posedge clk); @(negedge clk);
    ack_valid = 0;
  endtask

  // Lane 0 event; returns at the negedge after the capture edge
  task automatic trig(input int vp, input bit en, input bit pnd, input bit grp);
    @(negedge clk);
    vint_valid = 2'b01; vint_vp[VW-1:0] = VW'(vp);
    vint_en = {1'b0, en}; vint_pend = {1'b0, pnd}; vint_grp = {1'b0, grp};
    @(posedge clk); @(negedge clk);
    vint_valid = 0;
  endtask

  // Row: [7:4] vp, [3] enable, [2] pending, [1] group, [0] doorbell expected
  localparam logic [7:0] ROWS [10] = '{
    8'h1D,  // vp1 fresh, grp0: fires (R1)
    8'h24,  // vp2 disabled interrupt (R7)
    8'h2A,  // vp2 not pending (R7)
    8'h2F,  // vp2 grp1, never scheduled -> both groups on (R7)
    8'h5E,  // vp5 grp1 disabled at schedule (R7)
    8'h5D,  // vp5 grp0 enabled (R7)
    8'h6C,  // vp6 descheduled with flag 0 (R3)
    8'h7C,  // vp7 running (R2)
    8'h9C,  // vp9 no id mapped (R4)
    8'h1C   // vp1 second event in same idle period (R5)
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 db_valid after reset", db_valid, 0);
    chk("R10 db_pending after reset", db_pending, 0);
    rst = 0;

    for (int i = 0; i < 8; i++) do_map(i, 1, 100 + i);
    do_sched(5, 1, 0, 2'b01);
    do_sched(5, 0, 1, 2'b00);
    do_sched(6, 1, 0, 2'b11);
    do_sched(6, 0, 0, 2'b00);
    do_sched(7, 1, 0, 2'b11);
    chk("R10 no doorbell from setup", db_pending, 0);

    for (int k = 0; k < 10; k++) begin
      trig(ROWS[k][7:4], ROWS[k][3], ROWS[k][2], ROWS[k][1]);
      if (ROWS[k][0]) chk("R1 pending bit set", db_pending[ROWS[k][7:4]], 1);
      @(posedge clk); @(negedge clk);
      chk("R1/R2/R3/R4/R5/R7 doorbell presence", db_valid, ROWS[k][0]);
      if (ROWS[k][0]) begin
        chk("R1 doorbell vp", db_vp, ROWS[k][7:4]);
        chk("R1 doorbell id", db_id, 100 + ROWS[k][7:4]);
      end
      @(posedge clk); @(negedge clk);
      chk("R1 single pulse", db_valid, 0);
    end

    chk("R5 pending set after table", db_pending, 16'h0026);
    do_ack(3);
    chk("R8 ack on idle entry ignored", db_pending, 16'h0026);
    chk("R8 ack on idle entry no doorbell", db_valid, 0);
    do_ack(1);
    chk("R8 ack clears pending", db_pending, 16'h0024);
    trig(1, 1, 1, 0);
    @(posedge clk); @(negedge clk);
    chk("R5 ack does not re-arm", db_valid, 0);
    chk("R5 ack does not re-arm pending", db_pending[1], 0);

    do_sched(2, 1, 0, 2'b11);
    chk("R6 schedule clears pending", db_pending[2], 0);
    do_sched(2, 0, 1, 2'b00);
    trig(2, 1, 1, 1);
    @(posedge clk); @(negedge clk);
    chk("R5 re-armed after deschedule", db_valid, 1);
    chk("R5 re-armed id", db_id, 102);

    do_map(3, 0, 0);
    trig(3, 1, 1, 0);
    @(posedge clk); @(negedge clk);
    chk("R4 unmapped no doorbell", db_valid, 0);

    @(negedge clk);
    vint_valid = 2'b11; vint_vp = {4'd0, 4'd4};
    vint_en = 2'b11; vint_pend = 2'b11; vint_grp = 2'b00;
    @(posedge clk); @(negedge clk);
    vint_valid = 0;
    chk("R9 both pending", db_pending[0] & db_pending[4], 1);
    @(posedge clk); @(negedge clk);
    chk("R9 first emission valid", db_valid, 1);
    chk("R9 lowest index first", db_vp, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 second emission valid", db_valid, 1);
    chk("R9 second index", db_vp, 4);
    chk("R9 second id", db_id, 104);
    @(posedge clk); @(negedge clk);
    chk("R9 queue drained", db_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule